// File: doc/BRIEF.md
# Processor Input-Pin Interrupt Conditioner

This block sits between seven processor control pins and the core's interrupt and run-control logic. Pin activity arrives as synchronous updates: each update names one pin and carries its new level. The block stores the last accepted level of every pin. It acts on an update only when that update changes the stored level. Each pin then follows its own rule. Some pins make a pending bit follow their level. The machine-check pin raises its bit only on a falling edge. The checkstop pin halts and resumes the core. The hard-reset pin asks for a core reset. The time-base-enable pin is stored and does nothing else.

The result is a 12-bit pending-interrupt vector, a halted flag and a one-cycle reset request. Internal timer sources can also raise their own pending bits through a separate request input. An acknowledge mask clears pending bits, and an acknowledge wins over a set request in the same cycle. Choosing among pending sources and vectoring to handlers are left to the consumer.

Top module: `pin_irq_cond`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `pending` is 0, `halted` is 0 and `reset_req` is 0, and every stored pin level is 0.
- R2: An update whose level equals the stored level of that pin changes no output and no stored state. Example: the external pin is high, its bit has been acknowledged, and a repeated high update leaves bit 2 clear.
- R3: Pin index 5 is the external interrupt. A change of this pin sets pending bit 2 when the new level is 1 and clears it when the new level is 0.
- R4: Pin index 6 is the thermal interrupt. A change of this pin sets pending bit 6 when the new level is 1 and clears it when the new level is 0.
- R5: Pin index 4 is the machine check. A 1-to-0 change sets pending bit 1. A 0-to-1 change neither sets nor clears that bit.
- R6: Pin index 2 is the checkstop. A change to 1 sets `halted` and a change to 0 clears it. No other update moves `halted`.
- R7: Pin index 1 is the soft reset. A change of this pin makes pending bit 0 equal to the new level.
- R8: Pin index 0 is the hard reset. A 0-to-1 change raises `reset_req` for exactly one cycle. A 1-to-0 change raises nothing.
- R9: Pin index 3 is the time-base enable. A change of this pin is stored but changes no output.
- R10: `timer_req` bits 0 to 4 set pending bits 7 to 11 in that order: decrementer, hypervisor decrementer, programmable interval timer, fixed interval timer, watchdog. Set bits stay set until acknowledged. Pending bits 3 to 5 are always 0.
- R11: Each 1 bit in `ack` clears the same pending bit on the next clock edge. It takes priority over any set request for that bit in the same cycle.
- R12: An update with pin index 7 changes no output and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | A pin update is present this cycle |
| upd_pin | input | 3 | Index of the updated pin |
| upd_level | input | 1 | New level of that pin |
| timer_req | input | 5 | Set requests from the internal timer sources |
| ack | input | 12 | Acknowledge mask that clears pending bits |
| pending | output | 12 | Pending-interrupt vector |
| halted | output | 1 | Core is stopped by checkstop |
| reset_req | output | 1 | One-cycle core reset request |

## Verification
All three outputs are registered. An update, timer request or acknowledge presented in one cycle shows on `pending`, `halted` and `reset_req` just after the next rising edge. `reset_req` falls again one edge later. The bench drives every stimulus on a falling edge and returns the inputs to idle just after the following rising edge. It samples the outputs at that point and compares them with a model built from the requirements. After every hard-reset update it runs an idle cycle, which checks that the request ends after a single cycle.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  // pin indices (decoded by the pin driver, so they are fixed)
  localparam int PIN_COUNT   = 7;
  localparam int PIN_IDX_W   = 3;
  localparam int PIN_HRESET  = 0;
  localparam int PIN_SRESET  = 1;
  localparam int PIN_CKSTP   = 2;
  localparam int PIN_TBEN    = 3;
  localparam int PIN_MCHK    = 4;
  localparam int PIN_EXT     = 5;
  localparam int PIN_THERM   = 6;

  // pending vector layout
  localparam int PEND_W      = 12;
  localparam int PB_RESET    = 0;
  localparam int PB_MCHK     = 1;
  localparam int PB_EXT      = 2;
  localparam int PB_THERM    = 6;
  localparam int TIMER_BASE  = 7;
  localparam int TIMER_COUNT = 5;
endpackage

// File: rtl/pin_change_filter.sv
// Stores the last accepted level of each pin and flags real level changes.
module pin_change_filter #(
  parameter int NUM_PINS = 7,
  parameter int IDX_W    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_valid,
  input  logic [IDX_W-1:0]    upd_pin,
  input  logic                upd_level,
  input  logic [NUM_PINS-1:0] lvl_we,
  output logic [NUM_PINS-1:0] evt_sel,
  output logic                evt_level
);
  logic [NUM_PINS-1:0] lvl_q;
  logic [NUM_PINS-1:0] lvl_d;
  logic [NUM_PINS-1:0] pin_sel;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign pin_sel[i] = upd_valid && (upd_pin == IDX_W'(i));
    assign evt_sel[i] = pin_sel[i] && (lvl_q[i] != upd_level);
  end

  assign evt_level = upd_level;

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      lvl_d[i] = lvl_we[i] ? upd_level : lvl_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/pin_rule_decode.sv
// Turns a filtered pin change into per-pin actions.
module pin_rule_decode
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS   = PIN_COUNT,
  parameter int PW         = PEND_W,
  parameter logic [NUM_PINS-1:0] TRACK_MASK = '1
) (
  input  logic [NUM_PINS-1:0] evt_sel,
  input  logic                evt_level,
  output logic [PW-1:0]       pend_set,
  output logic [PW-1:0]       pend_clr,
  output logic                halt_we,
  output logic                halt_val,
  output logic                rst_pulse,
  output logic [NUM_PINS-1:0] lvl_we
);
  // every known pin stores its level on a change, including time-base enable
  assign lvl_we = evt_sel & TRACK_MASK;

  always_comb begin
    pend_set = '0;
    pend_clr = '0;
    // soft reset: level follower
    pend_set[PB_RESET] = evt_sel[PIN_SRESET] &  evt_level;
    pend_clr[PB_RESET] = evt_sel[PIN_SRESET] & ~evt_level;
    // machine check: falling edge only, never cleared by the pin
    pend_set[PB_MCHK]  = evt_sel[PIN_MCHK]   & ~evt_level;
    // external and thermal: level followers, active high
    pend_set[PB_EXT]   = evt_sel[PIN_EXT]    &  evt_level;
    pend_clr[PB_EXT]   = evt_sel[PIN_EXT]    & ~evt_level;
    pend_set[PB_THERM] = evt_sel[PIN_THERM]  &  evt_level;
    pend_clr[PB_THERM] = evt_sel[PIN_THERM]  & ~evt_level;
  end

  assign halt_we   = evt_sel[PIN_CKSTP];
  assign halt_val  = evt_level;
  assign rst_pulse = evt_sel[PIN_HRESET] & evt_level;
endmodule

// File: rtl/pending_reg.sv
// Pending bits with set, clear and acknowledge; acknowledge wins.
module pending_reg #(
  parameter int PW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] set,
  input  logic [PW-1:0] clr,
  input  logic [PW-1:0] ack,
  output logic [PW-1:0] q
);
  logic [PW-1:0] d;

  for (genvar i = 0; i < PW; i++) begin : g_bit
    always_comb begin
      if (ack[i])      d[i] = 1'b0;
      else if (clr[i]) d[i] = 1'b0;
      else if (set[i]) d[i] = 1'b1;
      else             d[i] = q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/pin_irq_cond.sv
module pin_irq_cond
  import pin_irq_pkg::*;
#(
  parameter int NUM_PINS   = PIN_COUNT,
  parameter int IDX_W      = PIN_IDX_W,
  parameter int PW         = PEND_W,
  parameter int NUM_TIMERS = TIMER_COUNT
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  upd_valid,
  input  logic [IDX_W-1:0]      upd_pin,
  input  logic                  upd_level,
  input  logic [NUM_TIMERS-1:0] timer_req,
  input  logic [PW-1:0]         ack,
  output logic [PW-1:0]         pending,
  output logic                  halted,
  output logic                  reset_req
);
  logic [NUM_PINS-1:0] evt_sel;
  logic [NUM_PINS-1:0] lvl_we;
  logic                evt_level;
  logic [PW-1:0]       pin_set;
  logic [PW-1:0]       pin_clr;
  logic [PW-1:0]       all_set;
  logic                halt_we;
  logic                halt_val;
  logic                rst_pulse;
  logic                halted_q;
  logic                halted_d;
  logic                rreq_q;
  logic                rreq_d;

  pin_change_filter #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_filter (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_pin   (upd_pin),
    .upd_level (upd_level),
    .lvl_we    (lvl_we),
    .evt_sel   (evt_sel),
    .evt_level (evt_level)
  );

  pin_rule_decode #(.NUM_PINS(NUM_PINS), .PW(PW)) u_decode (
    .evt_sel   (evt_sel),
    .evt_level (evt_level),
    .pend_set  (pin_set),
    .pend_clr  (pin_clr),
    .halt_we   (halt_we),
    .halt_val  (halt_val),
    .rst_pulse (rst_pulse),
    .lvl_we    (lvl_we)
  );

  assign all_set = pin_set | (PW'(timer_req) << TIMER_BASE);

  pending_reg #(.PW(PW)) u_pend (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (all_set),
    .clr   (pin_clr),
    .ack   (ack),
    .q     (pending)
  );

  always_comb begin
    halted_d = halt_we ? halt_val : halted_q;
    rreq_d   = rst_pulse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      rreq_q   <= 1'b0;
    end else begin
      halted_q <= halted_d;
      rreq_q   <= rreq_d;
    end
  end

  assign halted    = halted_q;
  assign reset_req = rreq_q;
endmodule

// File: rtl/pin_irq_cond_chk.sv
module pin_irq_cond_chk
  import pin_irq_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic [2:0]       upd_pin,
  input logic             upd_level,
  input logic [11:0]      ack,
  input logic [11:0]      pending,
  input logic             halted,
  input logic             reset_req
);
  p_gap_bits_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending[5:3] == 3'b000);

  p_ack_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != 12'd0) |=> ((pending & $past(ack)) == 12'd0));

  p_reset_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  p_mchk_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending[PB_MCHK] && !ack[PB_MCHK]) |=> pending[PB_MCHK]);

  p_halt_only_ckstp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd_valid && upd_pin == 3'(PIN_CKSTP)) |=> $stable(halted));

  p_ext_low_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_pin == 3'(PIN_EXT) && !upd_level) |=> !pending[PB_EXT]);
endmodule

bind pin_irq_cond pin_irq_cond_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_valid (upd_valid),
  .upd_pin   (upd_pin),
  .upd_level (upd_level),
  .ack       (ack),
  .pending   (pending),
  .halted    (halted),
  .reset_req (reset_req)
);

// File: tb/pin_irq_cond_bench.sv
module pin_irq_cond_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_valid;
  logic [2:0]  upd_pin;
  logic        upd_level;
  logic [4:0]  timer_req;
  logic [11:0] ack;
  logic [11:0] pending;
  logic        halted;
  logic        reset_req;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [6:0]  m_lvl;
  logic [11:0] m_pend;
  logic        m_halt;
  logic        m_rreq;

  always #10 clk = ~clk;

  pin_irq_cond u_pin_irq_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_pin   (upd_pin),
    .upd_level (upd_level),
    .timer_req (timer_req),
    .ack       (ack),
    .pending   (pending),
    .halted    (halted),
    .reset_req (reset_req)
  );

  function automatic string pin_tag(input logic [2:0] p);
    case (p)
      3'd0: return "R8";
      3'd1: return "R7";
      3'd2: return "R6";
      3'd3: return "R9";
      3'd4: return "R5";
      3'd5: return "R3";
      3'd6: return "R4";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if (pending !== m_pend || halted !== m_halt || reset_req !== m_rreq) begin
      fails++;
      $display("FAIL %s: pending=%h halted=%b reset_req=%b expected pending=%h halted=%b reset_req=%b",
               tag, pending, halted, reset_req, m_pend, m_halt, m_rreq);
    end
  endtask

  task automatic idle_inputs();
    upd_valid = 1'b0;
    upd_pin   = 3'd0;
    upd_level = 1'b0;
    timer_req = 5'd0;
    ack       = 12'd0;
  endtask

  // Drive one cycle of stimulus, update the model, check after the edge.
  task automatic apply(input logic v, input logic [2:0] p, input logic l,
                       input logic [11:0] a, input logic [4:0] t, input string tag);
    string tg;
    tg = (tag == "") ? pin_tag(p) : tag;
    @(negedge clk);
    upd_valid = v;
    upd_pin   = p;
    upd_level = l;
    ack       = a;
    timer_req = t;
    m_rreq = 1'b0;
    if (v && p < 3'd7) begin
      if (l == m_lvl[p]) begin
        tg = "R2";
      end else begin
        case (p)
          3'd0: m_rreq = l;
          3'd1: m_pend[0] = l;
          3'd2: m_halt = l;
          3'd4: if (!l) m_pend[1] = 1'b1;
          3'd5: m_pend[2] = l;
          3'd6: m_pend[6] = l;
          default: ;
        endcase
        m_lvl[p] = l;
      end
    end
    m_pend[11:7] = m_pend[11:7] | t;
    m_pend = m_pend & ~a;
    @(posedge clk);
    #1;
    idle_inputs();
    check(tg);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic lv [6];
    lv = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
    idle_inputs();
    m_lvl = '0; m_pend = '0; m_halt = 1'b0; m_rreq = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1");
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1");

    // sweep every pin index through changes and repeats
    for (int p = 0; p < 8; p++) begin
      for (int k = 0; k < 6; k++) begin
        apply(1'b1, 3'(p), lv[k], 12'd0, 5'd0, "");
        apply(1'b0, 3'd0, 1'b0, 12'd0, 5'd0, pin_tag(3'(p)));
      end
      apply(1'b0, 3'd0, 1'b0, 12'hFFF, 5'd0, "R11");
    end

    // R2: acknowledged external bit stays clear on a repeated high update
    apply(1'b1, 3'd5, 1'b1, 12'd0, 5'd0, "R3");
    apply(1'b0, 3'd0, 1'b0, 12'h004, 5'd0, "R11");
    apply(1'b1, 3'd5, 1'b1, 12'd0, 5'd0, "R2");

    // R11: acknowledge beats a set in the same cycle
    apply(1'b1, 3'd5, 1'b0, 12'd0, 5'd0, "R3");
    apply(1'b1, 3'd5, 1'b1, 12'h004, 5'd0, "R11");
    apply(1'b0, 3'd0, 1'b0, 12'h080, 5'h01, "R11");

    // R5: machine check set on fall, kept through a rise
    apply(1'b1, 3'd4, 1'b1, 12'd0, 5'd0, "R5");
    apply(1'b1, 3'd4, 1'b0, 12'd0, 5'd0, "R5");
    apply(1'b1, 3'd4, 1'b1, 12'd0, 5'd0, "R5");
    apply(1'b0, 3'd0, 1'b0, 12'h002, 5'd0, "R11");

    // R10: each timer source, sticky, then one-hot acknowledges
    for (int j = 0; j < 5; j++) begin
      apply(1'b0, 3'd0, 1'b0, 12'd0, 5'(1 << j), "R10");
      apply(1'b0, 3'd0, 1'b0, 12'd0, 5'd0, "R10");
    end
    for (int b = 0; b < 12; b++) begin
      apply(1'b0, 3'd0, 1'b0, 12'(1 << b), 5'd0, "R11");
    end

    // R6 and R9: checkstop resumes; time-base enable moves nothing
    apply(1'b1, 3'd2, 1'b1, 12'd0, 5'd0, "R6");
    apply(1'b1, 3'd3, 1'b1, 12'd0, 5'd0, "R9");
    apply(1'b1, 3'd2, 1'b0, 12'd0, 5'd0, "R6");
    apply(1'b1, 3'd3, 1'b0, 12'd0, 5'd0, "R9");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule